// File: doc/BRIEF.md
# Dual-Context Level Interrupt Controller with Shadow Masking

This block collects forty level-sensitive interrupt lines and presents them to a processor that runs two hardware thread contexts. Each context gets its own request output. Software enables or disables each source through two mask words and reads back enabled line status through two status words. All of this sits on a small synchronous 32-bit register bus.

Most sources are wired to exactly one context, chosen at integration time. A source can instead be paired with a spare interrupt number, its shadow. Such a source is offered to both contexts. Context 0 sees it when its own mask bit is set. Context 1 sees it when the shadow's mask bit is set, so each context can mask it independently. A shadow number stands for no real line: its input is ignored and its status bit reads zero.

The pairs are given as parameters. A pair is dropped if it names an out-of-range number, pairs a number with itself, or reuses a number already claimed by an earlier pair. Any number in a dropped pair keeps its ordinary routing.

Top module: `dual_ctx_intc`

## Requirements
- R1: After reset every mask bit is 0, both request outputs are low and both status words read 0, whatever the input lines do.
- R2: The low mask word at offset 0x04 is readable and writable; bit n enables source n (1 = enabled) for n = 0..31.
- R3: The high mask word at offset 0x50 holds sources 32..39 in bits 0..7; bits 8..31 read 0 and writes to them are dropped.
- R4: The status words at 0x08 (sources 0..31) and 0x54 (sources 32..39 in bits 0..7) show line AND mask for each real source, captured one clock after the line or mask changes. Shadow numbers read 0.
- R5: Writes to the status offsets have no effect. Reads of any unmapped offset return 0, and writes to unmapped offsets change nothing.
- R6: A source with no shadow goes to context 1 if its bit in parameter CTX1_ROUTE is set (by default only source 5), and otherwise to context 0. It never reaches both contexts.
- R7: For a paired target, the target's own mask bit gates it to context 0 and the shadow's mask bit gates it to context 1. The default pairs are (target 30, shadow 29) and (target 35, shadow 38).
- R8: The input line of a shadow number is ignored: it raises no request and sets no status bit, even while enabled.
- R9: A pair that reuses an already claimed target or shadow is dropped. The default third pair (30, 10) is dropped, so source 10 is an ordinary context-0 source and mask bit 10 does not gate target 30.
- R10: Each request output is the OR of that context's enabled sources. It is registered, changing at the first clock edge after the line or mask change is seen.
- R11: Read data is registered at the read cycle's clock edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| srcLines | input | 40 | Level interrupt inputs, bit n = source n |
| irqCtx0 | output | 1 | Request to context 0 |
| irqCtx1 | output | 1 | Request to context 1 |

## Verification
Routing is tried with one line active at a time: an ordinary context-0 source, the one context-1 source, a high-word source, and the two paired targets. Each target is tried under every combination of its own mask bit and its shadow's mask bit, which shows whether context 1 is gated by the shadow bit rather than the target bit. A status read with all lines high and a mixed line pattern checks that shadow positions are cleared while every other bit follows line AND mask. Driving a shadow line alone, and driving the number from a dropped pair, checks that a line which should have no effect leaves both outputs unchanged.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_MASK_LO,
    RD_MASK_HI,
    RD_PEND_LO,
    RD_PEND_HI
  } rdSel_e;

  typedef struct packed {
    logic   wrMaskLo;
    logic   wrMaskHi;
    logic   rdStrobe;
    rdSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/intc_route_map.sv
module intc_route_map #(
  parameter int NUM_SRC = 40,
  parameter int NUM_PAIRS = 3,
  parameter int IDX_W = 6,
  parameter logic [NUM_PAIRS*8-1:0] PAIR_TARGET = '0,
  parameter logic [NUM_PAIRS*8-1:0] PAIR_SHADOW = '0,
  parameter logic [NUM_SRC-1:0] CTX1_ROUTE = '0
) (
  output logic [NUM_SRC-1:0]       shadowMap,
  output logic [NUM_SRC-1:0]       ctx0Sel,
  output logic [NUM_SRC-1:0]       ctx1Sel,
  output logic [NUM_SRC*IDX_W-1:0] gateIdx
);

  logic [NUM_SRC-1:0] targetMap;

  // Pairs are taken in index order; a later pair that collides is dropped.
  always_comb begin
    shadowMap = '0;
    targetMap = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      gateIdx[i*IDX_W +: IDX_W] = IDX_W'(i);
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin : pairScan
      logic [7:0] tgt;
      logic [7:0] shd;
      logic [IDX_W-1:0] ti;
      logic [IDX_W-1:0] si;
      tgt = PAIR_TARGET[p*8 +: 8];
      shd = PAIR_SHADOW[p*8 +: 8];
      ti = tgt[IDX_W-1:0];
      si = shd[IDX_W-1:0];
      if (tgt < 8'(NUM_SRC) && shd < 8'(NUM_SRC) && tgt != shd) begin
        if (!shadowMap[ti] && !targetMap[ti] && !shadowMap[si] && !targetMap[si]) begin
          targetMap[ti] = 1'b1;
          shadowMap[si] = 1'b1;
          gateIdx[int'(ti)*IDX_W +: IDX_W] = si;
        end
      end
    end
  end

  assign ctx0Sel = ~shadowMap & (targetMap | ~CTX1_ROUTE);
  assign ctx1Sel = ~shadowMap & (targetMap | CTX1_ROUTE);

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import dual_intc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_LO_OFF = 8'h04,
  parameter logic [ADDR_W-1:0] MASK_HI_OFF = 8'h50,
  parameter logic [ADDR_W-1:0] PEND_LO_OFF = 8'h08,
  parameter logic [ADDR_W-1:0] PEND_HI_OFF = 8'h54
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrb_t         strb
);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_ZERO;
    if (busSel) begin
      if (busWr) begin
        strb.wrMaskLo = (busAddr == MASK_LO_OFF);
        strb.wrMaskHi = (busAddr == MASK_HI_OFF);
      end else begin
        strb.rdStrobe = 1'b1;
        case (busAddr)
          MASK_LO_OFF: strb.rdSel = RD_MASK_LO;
          MASK_HI_OFF: strb.rdSel = RD_MASK_HI;
          PEND_LO_OFF: strb.rdSel = RD_PEND_LO;
          PEND_HI_OFF: strb.rdSel = RD_PEND_HI;
          default:     strb.rdSel = RD_ZERO;
        endcase
      end
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import dual_intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int IDX_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_SRC-1:0]       srcLines,
  input  logic [NUM_SRC-1:0]       shadowMap,
  input  logic [NUM_SRC-1:0]       ctx0Sel,
  input  logic [NUM_SRC-1:0]       ctx1Sel,
  input  logic [NUM_SRC*IDX_W-1:0] gateIdx,
  output logic [DATA_W-1:0]        rdata,
  output logic                     irq0,
  output logic                     irq1
);

  localparam int HI_W = NUM_SRC - DATA_W;

  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] gate1;
  logic [NUM_SRC-1:0] eff0;
  logic [NUM_SRC-1:0] eff1;
  logic [DATA_W-1:0]  rdNext;
  logic               irq0Q;
  logic               irq1Q;

  // Context-1 gate: each source picks the mask bit named by its gate index.
  for (genvar i = 0; i < NUM_SRC; i++) begin : gGate
    assign gate1[i] = maskQ[gateIdx[i*IDX_W +: IDX_W]];
  end

  assign eff0 = srcLines & maskQ & ctx0Sel;
  assign eff1 = srcLines & gate1 & ctx1Sel;

  always_comb begin
    case (strb.rdSel)
      RD_MASK_LO: rdNext = maskQ[DATA_W-1:0];
      RD_MASK_HI: rdNext = DATA_W'(maskQ[NUM_SRC-1:DATA_W]);
      RD_PEND_LO: rdNext = pendQ[DATA_W-1:0];
      RD_PEND_HI: rdNext = DATA_W'(pendQ[NUM_SRC-1:DATA_W]);
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      pendQ <= '0;
      irq0Q <= 1'b0;
      irq1Q <= 1'b0;
      rdata <= '0;
    end else begin
      if (strb.wrMaskLo) maskQ[DATA_W-1:0] <= wdata;
      if (strb.wrMaskHi) maskQ[NUM_SRC-1:DATA_W] <= wdata[HI_W-1:0];
      pendQ <= srcLines & maskQ & ~shadowMap;
      irq0Q <= |eff0;
      irq1Q <= |eff1;
      if (strb.rdStrobe) rdata <= rdNext;
    end
  end

  assign irq0 = irq0Q;
  assign irq1 = irq1Q;

  // R1/R10: with nothing enabled, no request can follow
  assert_quiet_when_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> (!irq0Q && !irq1Q));

  // R2: a low-word write lands in the mask
  assert_mask_lo_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskLo |=> (maskQ[DATA_W-1:0] == $past(wdata)));

  // R3: high status/mask reads never carry bits beyond the source count
  assert_hi_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStrobe && (strb.rdSel == RD_MASK_HI || strb.rdSel == RD_PEND_HI))
      |=> (rdata[DATA_W-1:HI_W] == '0));

  // R8: shadow positions never show status
  assert_shadow_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & shadowMap) == '0));

  // R11: read data holds between reads
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStrobe |=> $stable(rdata));

endmodule

// File: rtl/dual_ctx_intc.sv
module dual_ctx_intc
  import dual_intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_PAIRS = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [NUM_PAIRS*8-1:0] PAIR_TARGET = {8'd30, 8'd35, 8'd30},
  parameter logic [NUM_PAIRS*8-1:0] PAIR_SHADOW = {8'd10, 8'd38, 8'd29},
  parameter logic [NUM_SRC-1:0] CTX1_ROUTE = 40'h00_0000_0020
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcLines,
  output logic               irqCtx0,
  output logic               irqCtx1
);

  localparam int IDX_W = $clog2(NUM_SRC);

  ctrlStrb_t                strb;
  logic [NUM_SRC-1:0]       shadowMap;
  logic [NUM_SRC-1:0]       ctx0Sel;
  logic [NUM_SRC-1:0]       ctx1Sel;
  logic [NUM_SRC*IDX_W-1:0] gateIdx;

  intc_route_map #(
    .NUM_SRC(NUM_SRC), .NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W),
    .PAIR_TARGET(PAIR_TARGET), .PAIR_SHADOW(PAIR_SHADOW), .CTX1_ROUTE(CTX1_ROUTE)
  ) uMap (
    .shadowMap(shadowMap), .ctx0Sel(ctx0Sel), .ctx1Sel(ctx1Sel), .gateIdx(gateIdx)
  );

  intc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .strb(strb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .srcLines(srcLines),
    .shadowMap(shadowMap), .ctx0Sel(ctx0Sel), .ctx1Sel(ctx1Sel), .gateIdx(gateIdx),
    .rdata(busRdata), .irq0(irqCtx0), .irq1(irqCtx1)
  );

endmodule

// File: tb/sim_dual_ctx_intc.sv
module sim_dual_ctx_intc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [39:0] srcLines = '0;
  logic        irqCtx0;
  logic        irqCtx1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dual_ctx_intc u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcLines(srcLines),
    .irqCtx0(irqCtx0), .irqCtx1(irqCtx1)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [31:0] data);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] addr, output logic [31:0] data);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr;
    @(negedge clk);
    busSel = 1'b0;
    data = busRdata;
  endtask

  task automatic checkIrq(input string req, input logic e0, input logic e1);
    check(req, {62'd0, irqCtx0, irqCtx1}, {62'd0, e0, e1});
  endtask

  task automatic testReset();
    logic [31:0] d;
    checkIrq("R1 irq after reset", 1'b0, 1'b0);
    busRead(8'h04, d); check("R1 mask lo", d, 0);
    busRead(8'h50, d); check("R1 mask hi", d, 0);
    busRead(8'h08, d); check("R1 status lo", d, 0);
    busRead(8'h54, d); check("R1 status hi", d, 0);
  endtask

  task automatic testMaskRw();
    logic [31:0] d;
    busWrite(8'h04, 32'hA5A5_0F0F);
    busRead(8'h04, d); check("R2 mask lo readback", d, 32'hA5A5_0F0F);
    busWrite(8'h50, 32'hFFFF_FF3C);
    busRead(8'h50, d); check("R3 mask hi upper bits", d, 32'h0000_003C);
  endtask

  task automatic testStatus();
    logic [31:0] d;
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h50, 32'hFFFF_FFFF);
    srcLines = 40'hC3_7234_5678;
    settle();
    busRead(8'h08, d); check("R4 status lo, shadow 29 cleared", d, 32'h5234_5678);
    busRead(8'h54, d); check("R4 status hi, shadow 38 cleared", d, 32'h0000_0083);
    busWrite(8'h04, 32'h0000_FFFF);
    settle();
    busRead(8'h08, d); check("R4 status follows mask", d, 32'h0000_5678);
    busWrite(8'h08, 32'h0);
    busRead(8'h08, d); check("R5 write to status lo ignored", d, 32'h0000_5678);
    busWrite(8'h54, 32'h0);
    busRead(8'h54, d); check("R5 write to status hi ignored", d, 32'h0000_0083);
    busRead(8'h20, d); check("R5 unmapped read", d, 0);
    busWrite(8'h20, 32'h0);
    busRead(8'h04, d); check("R5 unmapped write no effect", d, 32'h0000_FFFF);
  endtask

  task automatic testRouting();
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h50, 32'h0000_00FF);
    srcLines = '0; settle();
    checkIrq("R10 idle lines", 1'b0, 1'b0);
    srcLines = 40'h1 << 5; settle();
    checkIrq("R6 source 5 to context 1 only", 1'b0, 1'b1);
    srcLines = 40'h1 << 7; settle();
    checkIrq("R6 source 7 to context 0 only", 1'b1, 1'b0);
    srcLines = 40'h1 << 10; settle();
    checkIrq("R9 source 10 ordinary", 1'b1, 1'b0);
    srcLines = 40'h1 << 33; settle();
    checkIrq("R6 source 33 to context 0", 1'b1, 1'b0);
    busWrite(8'h04, 32'hFFFF_FFDF);
    srcLines = 40'h1 << 5; settle();
    checkIrq("R6 source 5 masked", 1'b0, 1'b0);
  endtask

  task automatic testShadow();
    busWrite(8'h50, 32'h0);
    srcLines = 40'h1 << 30;
    busWrite(8'h04, 32'h4000_0000); settle();
    checkIrq("R7 target 30 own bit only", 1'b1, 1'b0);
    busWrite(8'h04, 32'h2000_0000); settle();
    checkIrq("R7 target 30 shadow bit only", 1'b0, 1'b1);
    busWrite(8'h04, 32'h6000_0000); settle();
    checkIrq("R7 target 30 both bits", 1'b1, 1'b1);
    busWrite(8'h04, 32'h0); settle();
    checkIrq("R7 target 30 neither bit", 1'b0, 1'b0);
    srcLines = 40'h1 << 35;
    busWrite(8'h50, 32'h40); settle();
    checkIrq("R7 target 35 via shadow 38", 1'b0, 1'b1);
    busWrite(8'h50, 32'h08); settle();
    checkIrq("R7 target 35 own bit", 1'b1, 1'b0);
    srcLines = 40'h1 << 30;
    busWrite(8'h50, 32'h0);
    busWrite(8'h04, 32'h0000_0400); settle();
    checkIrq("R9 bit 10 does not gate target 30", 1'b0, 1'b0);
  endtask

  task automatic testShadowLine();
    logic [31:0] d;
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h50, 32'h0000_00FF);
    srcLines = (40'h1 << 29) | (40'h1 << 38);
    settle();
    checkIrq("R8 shadow lines ignored", 1'b0, 1'b0);
    busRead(8'h08, d); check("R8 status lo shadow", d, 0);
    busRead(8'h54, d); check("R8 status hi shadow", d, 0);
  endtask

  task automatic testTiming();
    logic [31:0] d;
    busWrite(8'h50, 32'h0);
    busWrite(8'h04, 32'h0000_0008);
    srcLines = '0; settle();
    srcLines = 40'h1 << 3;
    #1 checkIrq("R10 no change before edge", 1'b0, 1'b0);
    settle();
    checkIrq("R10 rises after one edge", 1'b1, 1'b0);
    srcLines = '0;
    #1 checkIrq("R10 held before edge", 1'b1, 1'b0);
    settle();
    checkIrq("R10 falls after one edge", 1'b0, 1'b0);
    busRead(8'h04, d); check("R11 read value", d, 32'h0000_0008);
    srcLines = 40'hFF_FFFF_FFFF;
    repeat (3) settle();
    check("R11 read data holds", busRdata, 32'h0000_0008);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    srcLines = 40'hFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    testReset();
    testMaskRw();
    testStatus();
    testRouting();
    testShadow();
    testShadowLine();
    testTiming();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule